// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, of configurable width. Each direction has its own storage register with its own clock. The A-to-B register samples the A bus and the B-to-A register samples the B bus. Each register keeps sampling on its own clock whether or not any output is enabled. Each bus is modelled as three separate ports: an input, an output value and an output enable. The block therefore holds no tri-state logic. Pad logic outside the block turns the enable and value into a real bus driver.

For each direction, a select line picks what the output carries: the live value from the opposite bus, or the stored register word. The output enables are steered by an active-low master enable and a direction input. The steering decodes into one of three named modes:

- MODE_ISOLATE: the master enable is high and neither bus is driven.
- MODE_A_TO_B: the master enable is low and direction is 1, so B is driven.
- MODE_B_TO_A: the master enable is low and direction is 0, so A is driven.

Moving between these modes is purely combinational. Any combination of the master enable and direction inputs reaches its mode directly. The output value on each side is formed per bit by a two-level AND-OR network. That network adds a consensus term, so a select change never produces a bit that matches neither source.

Top module: `xcvr_reg_bridge`

## Requirements
- R1: On a rising edge of `clk_ab` with `rst` low, the A-to-B register loads `a_in`. Edges of `clk_ba` leave it unchanged.
- R2: On a rising edge of `clk_ba` with `rst` low, the B-to-A register loads `b_in`. Edges of `clk_ab` leave it unchanged.
- R3: With `oe_n`=0, the enables follow the direction input. `dir`=1 gives `b_oe`=1 and `a_oe`=0 (MODE_A_TO_B). `dir`=0 gives `a_oe`=1 and `b_oe`=0 (MODE_B_TO_A).
- R4: With `oe_n`=1 (MODE_ISOLATE), `a_oe` and `b_oe` are both 0, whatever the values of `dir` and the selects.
- R5: `a_oe` and `b_oe` are never 1 at the same time.
- R6: While `oe_n`=1, both registers still load on their own clock edges, each independently of the other.
- R7: `sel_ab`=0 puts `a_in` on `b_out`. `sel_ab`=1 puts the A-to-B register on `b_out`.
- R8: `sel_ba`=0 puts `b_in` on `a_out`. `sel_ba`=1 puts the B-to-A register on `a_out`.
- R9: `a_out` and `b_out` carry their selected value whether or not the matching enable is active.
- R10: When `rst` is 1 at a rising edge of a register's own clock, that register clears to 0. The other register keeps its contents until its own clock sees `rst`.
- R11: At every instant, each bit of `b_out` equals the same bit of `a_in` or of the A-to-B register. Each bit of `a_out` likewise equals the same bit of `b_in` or of the B-to-A register. This holds across select changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, sampled by each capture clock |
| oe_n | input | 1 | Active-low master output enable |
| dir | input | 1 | Direction: 1 drives B, 0 drives A |
| sel_ab | input | 1 | B-side select: 0 live A, 1 stored word |
| sel_ba | input | 1 | A-side select: 0 live B, 1 stored word |
| a_in | input | W | Value seen on bus A |
| b_in | input | W | Value seen on bus B |
| a_out | output | W | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The hardest case to reach is a register moving while it is invisible on the buses. It must load in isolation mode, or load from one domain while the other domain is held in reset. Neither can be seen through an enable. The stimulus gates each capture clock separately from a free-running clock, so one domain can pulse while the other stays still. Every stored word is read back through the unconditioned output value by setting the select to 1, and the other register is checked to be unchanged. Glitch freedom is checked by a monitor that watches every change of the outputs while the selects toggle over live and stored words whose bits differ in a mixed pattern.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_A_TO_B  = 2'd1,
        MODE_B_TO_A  = 2'd2
    } xcvr_mode_e;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R1 / R2: a clean edge loads the bus value sampled at that edge
    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d)));

    // R10: reset seen by this clock clears this register
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/xcvr_sel.sv
module xcvr_sel #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out
);

    // Per-bit hazard-free AND-OR: the consensus term keeps the bit steady
    // when both sources agree and the select flips.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign out[i] = (live[i] & ~sel) | (stored[i] & sel) | (live[i] & stored[i]);
    end

    // R11: no bit ever takes a value neither source holds
    always_comb begin
        if (!$isunknown({sel, live, stored})) begin
            p_no_mix_r11: assert (((out ^ live) & (out ^ stored)) == '0);
        end
    end

endmodule

// File: rtl/xcvr_steer.sv
module xcvr_steer
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);

    xcvr_mode_e mode;

    always_comb begin
        unique case ({oe_n, dir})
            2'b00:   mode = MODE_B_TO_A;
            2'b01:   mode = MODE_A_TO_B;
            default: mode = MODE_ISOLATE;
        endcase
    end

    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (mode)
            MODE_A_TO_B:  b_oe = 1'b1;
            MODE_B_TO_A:  a_oe = 1'b1;
            MODE_ISOLATE: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
            default: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (!$isunknown({oe_n, dir})) begin
            // R5: one bus at most
            p_one_driver_r5: assert (!(a_oe && b_oe));
            // R4: master enable high releases both buses
            p_isolate_r4: assert (!oe_n || (!a_oe && !b_oe));
        end
    end

endmodule

// File: rtl/xcvr_reg_bridge.sv
module xcvr_reg_bridge #(
    parameter int W = 8
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] held_ab;
    logic [W-1:0] held_ba;

    xcvr_store #(.W(W)) u_store_ab (
        .clk (clk_ab),
        .rst (rst),
        .d   (a_in),
        .q   (held_ab)
    );

    xcvr_store #(.W(W)) u_store_ba (
        .clk (clk_ba),
        .rst (rst),
        .d   (b_in),
        .q   (held_ba)
    );

    xcvr_sel #(.W(W)) u_sel_b (
        .sel    (sel_ab),
        .live   (a_in),
        .stored (held_ab),
        .out    (b_out)
    );

    xcvr_sel #(.W(W)) u_sel_a (
        .sel    (sel_ba),
        .live   (b_in),
        .stored (held_ba),
        .out    (a_out)
    );

    xcvr_steer u_steer (
        .oe_n (oe_n),
        .dir  (dir),
        .a_oe (a_oe),
        .b_oe (b_oe)
    );

    // R3: an enabled B side is only ever the result of direction 1
    always_comb begin
        if (!$isunknown({oe_n, dir})) begin
            p_dir_b_r3: assert (!b_oe || (!oe_n && dir));
            p_dir_a_r3: assert (!a_oe || (!oe_n && !dir));
        end
    end

endmodule

// File: tb/xcvr_reg_bridge_bench.sv
module xcvr_reg_bridge_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    logic gate_ab = 1'b0;
    logic gate_ba = 1'b0;
    logic clk_ab, clk_ba;
    logic rst = 1'b0;
    logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;

    int total = 0;
    int bad = 0;
    logic [W-1:0] exp_ab = '0;
    logic [W-1:0] exp_ba = '0;
    logic mon_on = 1'b0;

    always #2 clk = ~clk;
    assign clk_ab = clk & gate_ab;
    assign clk_ba = clk & gate_ba;

    xcvr_reg_bridge #(.W(W)) u_xcvr_reg_bridge (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst (rst),
        .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .b_in (b_in),
        .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe)
    );

    // {oe_n, dir, sel_ab, sel_ba, expected a_oe, expected b_oe}
    localparam logic [5:0] VEC [16] = '{
        6'b0000_10, 6'b0001_10, 6'b0010_10, 6'b0011_10,
        6'b0100_01, 6'b0101_01, 6'b0110_01, 6'b0111_01,
        6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
        6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, want);
        end
    endtask

    task automatic pulse_ab();
        @(negedge clk) gate_ab = 1'b1;
        @(negedge clk) gate_ab = 1'b0;
    endtask

    task automatic pulse_ba();
        @(negedge clk) gate_ba = 1'b1;
        @(negedge clk) gate_ba = 1'b0;
    endtask

    // R11 monitor: every output change shows bits of live or stored only
    always @(b_out) begin
        if (mon_on) check("R11 b_out mix", ((b_out ^ a_in) & (b_out ^ exp_ab)), '0);
    end
    always @(a_out) begin
        if (mon_on) check("R11 a_out mix", ((a_out ^ b_in) & (a_out ^ exp_ba)), '0);
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // reset state, R10
        a_in = 8'hFF; b_in = 8'hFF;
        @(negedge clk) rst = 1'b1;
        pulse_ab();
        pulse_ba();
        rst = 1'b0;
        sel_ab = 1'b1; sel_ba = 1'b1; oe_n = 1'b1;
        #1;
        check("R10 reset b_out", b_out, 8'h00);
        check("R10 reset a_out", a_out, 8'h00);
        check("R4 reset enables", {6'b0, a_oe, b_oe}, 8'h00);

        // R1 / R2: independent captures
        a_in = 8'h3C; pulse_ab(); exp_ab = 8'h3C; #1;
        check("R1 load ab", b_out, exp_ab);
        check("R2 ba untouched by clk_ab", a_out, 8'h00);
        b_in = 8'hA5; pulse_ba(); exp_ba = 8'hA5; #1;
        check("R2 load ba", a_out, exp_ba);
        check("R1 ab untouched by clk_ba", b_out, exp_ab);

        // 16-combination table, R3 R4 R5 R7 R8 R9
        a_in = 8'h5A; b_in = 8'hC3;
        for (int i = 0; i < 16; i++) begin
            {oe_n, dir, sel_ab, sel_ba} = VEC[i][5:2];
            #1;
            check($sformatf("R3/R4 enables vec %0d", i), {6'b0, a_oe, b_oe}, {6'b0, VEC[i][1:0]});
            check($sformatf("R5 exclusive vec %0d", i), {7'b0, a_oe & b_oe}, 8'h00);
            check($sformatf("R7/R9 b_out vec %0d", i), b_out, sel_ab ? exp_ab : a_in);
            check($sformatf("R8/R9 a_out vec %0d", i), a_out, sel_ba ? exp_ba : b_in);
            #3;
        end

        // R6: captures continue in isolation
        oe_n = 1'b1; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'h96; pulse_ab(); exp_ab = 8'h96; #1;
        check("R6 isolate load ab", b_out, exp_ab);
        check("R6 isolate ba kept", a_out, exp_ba);
        b_in = 8'h0F; pulse_ba(); exp_ba = 8'h0F; #1;
        check("R6 isolate load ba", a_out, exp_ba);
        check("R6 isolate ab kept", b_out, exp_ab);
        check("R4 isolate enables", {6'b0, a_oe, b_oe}, 8'h00);

        // R11: select toggling with mixed live/stored patterns
        a_in = 8'hA5; b_in = 8'h33;
        mon_on = 1'b1;
        for (int k = 0; k < 8; k++) begin
            #1 sel_ab = ~sel_ab;
            #1 sel_ba = ~sel_ba;
            #1 a_in = a_in ^ 8'h18;
        end
        mon_on = 1'b0;
        sel_ab = 1'b0; sel_ba = 1'b0; #1;
        check("R7 live after toggling", b_out, a_in);
        check("R8 live after toggling", a_out, b_in);

        // R10: reset seen by one domain only
        sel_ab = 1'b1; sel_ba = 1'b1;
        @(negedge clk) rst = 1'b1;
        pulse_ab();
        rst = 1'b0; exp_ab = 8'h00; #1;
        check("R10 ab cleared", b_out, 8'h00);
        check("R10 ba kept", a_out, exp_ba);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule